// File: doc/BRIEF.md
# Carry Select Adder

This block adds two unsigned binary operands and a carry-in, producing a sum of the same width and a carry-out. It has no clock and no reset. The sum appears after the adder's logic delay.

The operand is split into a low part and a high part. The high part is built twice: one copy assumes no carry arrives from the low part, and the other assumes a carry does. Both copies and the low part start work at the same moment. The low part's carry-out then picks which high result, and which carry-out, leaves the block. The high result is therefore ready after a single select stage, not after the low carry has rippled through every high bit.

A depth parameter applies the same split again inside each part. Depth 0 gives a plain ripple chain. Depth 1 gives one split. Deeper settings keep halving until a part is too narrow to split.

Top module: `carry_select_adder`

## Requirements
- R1: For every input, {carry_out, sum} equals op_a + op_b + carry_in computed in WIDTH+1 bits, so sum is the total modulo 2^WIDTH and carry_out is bit WIDTH of the total.
- R2: At each split level, the low part covers the floor(W/2) least significant bits and the high part covers the rest. The two high copies receive fixed carry-ins of 0 and 1, so their results always differ by exactly one.
- R3: The low part's carry-out chooses the high bits of the sum and the final carry-out. When the low part produces a carry, that carry appears in the high bits: for example 0x0000FFFF + 0x00000001 gives 0x00010000.
- R4: The leaf adder is a ripple chain. Each bit's carry-out drives the carry into the next higher bit, and carry_in enters at bit 0.
- R5: Each one-bit cell produces a sum bit of 1 when an odd count of its three inputs is 1. It produces a carry of 1 when both operand bits are 1, or when exactly one of them is 1 and the incoming carry is 1.
- R6: Any setting of LEVELS (0 = flat ripple chain, 1 = one split, higher = repeated splits) gives identical outputs for identical inputs.
- R7: A carry from bit 0 must be able to travel through every bit. All-ones plus one gives a sum of 0 with carry_out 1, and 0xAAAAAAAA + 0x55555555 + 1 gives the same result.
- R8: The block is purely combinational. The outputs follow the current inputs within the same time step, with no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| carry_out | output | 1 | Bit WIDTH of the total |

## Verification
The assertions check four things whenever their inputs change:
- every one-bit cell matches its arithmetic count;
- every ripple leaf matches its own arithmetic total;
- every pair of high copies differs by exactly one;
- the top result equals the arithmetic total.

Some properties can only be shown by the bench's scenarios. These are that the low carry truly lands in the high bits at the split boundary, that a carry can cross the whole word, and that flat, single-split and deep builds agree. The bench shows them by driving boundary vectors and random vectors into three builds at once.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;
  // Width of the low part when a part of width w is split.
  function automatic int low_width(input int w);
    return w / 2;
  endfunction

  // Width of the high part when a part of width w is split.
  function automatic int high_width(input int w);
    return w - (w / 2);
  endfunction

  // Narrowest part that is still split further.
  localparam int MIN_SPLIT_WIDTH = 4;
endpackage

// File: rtl/csa_bit_cell.sv
`timescale 1ns/1ps
module csa_bit_cell (
  input  logic x,
  input  logic y,
  input  logic c_in,
  output logic s,
  output logic c_out
);
  logic half_s;
  logic half_c;

  // Two half-adder stages.
  always_comb begin
    half_s = x ^ y;
    half_c = x & y;
    s      = half_s ^ c_in;
    c_out  = half_c | (half_s & c_in);
  end

  always_comb begin
    AST_CELL_COUNT: assert ({c_out, s} == (2'(x) + 2'(y) + 2'(c_in)))
      else $error("bit cell disagrees with its input count"); // R5
  end
endmodule

// File: rtl/csa_ripple.sv
`timescale 1ns/1ps
module csa_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  output logic [W-1:0] s,
  output logic         c_out
);
  logic [W:0] chain;
  logic [W:0] total_chk;

  assign chain[0] = c_in;

  // Carry chain: each cell's carry-out feeds the next higher cell.
  for (genvar i = 0; i < W; i++) begin : g_cell
    csa_bit_cell u_cell (
      .x    (x[i]),
      .y    (y[i]),
      .c_in (chain[i]),
      .s    (s[i]),
      .c_out(chain[i+1])
    );
  end

  assign c_out = chain[W];

  always_comb begin
    total_chk = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c_in};
    AST_RIPPLE_TOTAL: assert ({c_out, s} == total_chk)
      else $error("ripple leaf total mismatch"); // R4
  end
endmodule

// File: rtl/csa_stage.sv
`timescale 1ns/1ps
module csa_stage #(
  parameter int W      = 16,
  parameter int LEVELS = 1
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         c_in,
  output logic [W-1:0] s,
  output logic         c_out
);
  import csa_pkg::*;

  if (LEVELS == 0 || W < MIN_SPLIT_WIDTH) begin : g_leaf
    csa_ripple #(.W(W)) u_leaf (
      .x    (x),
      .y    (y),
      .c_in (c_in),
      .s    (s),
      .c_out(c_out)
    );
  end else begin : g_split
    localparam int LO = low_width(W);
    localparam int HI = high_width(W);

    logic [LO-1:0] lo_s;
    logic          lo_c;
    logic [HI-1:0] hi0_s;
    logic          hi0_c;
    logic [HI-1:0] hi1_s;
    logic          hi1_c;

    // Low part.
    csa_stage #(.W(LO), .LEVELS(LEVELS-1)) u_low (
      .x    (x[LO-1:0]),
      .y    (y[LO-1:0]),
      .c_in (c_in),
      .s    (lo_s),
      .c_out(lo_c)
    );

    // High part, copy that assumes no incoming carry.
    csa_stage #(.W(HI), .LEVELS(LEVELS-1)) u_high_c0 (
      .x    (x[W-1:LO]),
      .y    (y[W-1:LO]),
      .c_in (1'b0),
      .s    (hi0_s),
      .c_out(hi0_c)
    );

    // High part, copy that assumes an incoming carry.
    csa_stage #(.W(HI), .LEVELS(LEVELS-1)) u_high_c1 (
      .x    (x[W-1:LO]),
      .y    (y[W-1:LO]),
      .c_in (1'b1),
      .s    (hi1_s),
      .c_out(hi1_c)
    );

    // The low carry picks one high result and its carry-out.
    always_comb begin
      s[LO-1:0] = lo_s;
      if (lo_c) begin
        s[W-1:LO] = hi1_s;
        c_out     = hi1_c;
      end else begin
        s[W-1:LO] = hi0_s;
        c_out     = hi0_c;
      end
    end

    always_comb begin
      AST_SPEC_PAIR_STEP: assert ({hi1_c, hi1_s} == ({hi0_c, hi0_s} + (HI+1)'(1)))
        else $error("high copies do not differ by one"); // R2
    end
  end
endmodule

// File: rtl/carry_select_adder.sv
`timescale 1ns/1ps
module carry_select_adder #(
  parameter int WIDTH  = 32,
  parameter int LEVELS = 1
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int TOTAL_W = WIDTH + 1;

  logic [TOTAL_W-1:0] total_chk;

  csa_stage #(.W(WIDTH), .LEVELS(LEVELS)) u_root (
    .x    (op_a),
    .y    (op_b),
    .c_in (carry_in),
    .s    (sum),
    .c_out(carry_out)
  );

  always_comb begin
    total_chk = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    AST_TOTAL_MATCH: assert ({carry_out, sum} == total_chk)
      else $error("adder total mismatch"); // R1
  end
endmodule

// File: tb/test_carry_select_adder.sv
`timescale 1ns/1ps
module test_carry_select_adder;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a;
  logic [W-1:0] b;
  logic         ci;
  logic [W-1:0] s_one;
  logic [W-1:0] s_flat;
  logic [W-1:0] s_deep;
  logic         co_one;
  logic         co_flat;
  logic         co_deep;
  int           n_checks;
  int           n_fail;
  bit           done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  carry_select_adder #(.WIDTH(W), .LEVELS(1)) i_carry_select_adder (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_one), .carry_out(co_one));
  carry_select_adder #(.WIDTH(W), .LEVELS(0)) i_carry_select_adder_flat (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_flat), .carry_out(co_flat));
  carry_select_adder #(.WIDTH(W), .LEVELS(3)) i_carry_select_adder_deep (
    .op_a(a), .op_b(b), .carry_in(ci), .sum(s_deep), .carry_out(co_deep));

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h ci=%0d actual=%h expected=%h", tag, a, b, ci, got, exp);
    end
  endtask

  // Behavioural model: 64-bit integer arithmetic.
  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
    longint t;
    t = longint'(x) + longint'(y) + longint'(c);
    return t[W:0];
  endfunction

  // Drive after a rising edge, compare at the next falling edge.
  task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c, input string tag);
    @(posedge clk);
    a  = x;
    b  = y;
    ci = c;
    @(negedge clk);
    check({tag, " lvl1"}, {co_one, s_one}, model(x, y, c));
    check({tag, " R6 flat"}, {co_flat, s_flat}, model(x, y, c));
    check({tag, " R6 deep"}, {co_deep, s_deep}, model(x, y, c));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    a        = '0;
    b        = '0;
    ci       = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 zero inputs during bench reset", {co_one, s_one}, '0);
    rst_n = 1'b1;

    // R8: a second input change within one time step is followed at once.
    a = 32'h0000_0003;
    b = 32'h0000_0004;
    #0.1;
    check("R8 same-step response", {co_one, s_one}, 33'h0_0000_0007);

    // R5: every combination of the three inputs of the bit-0 cell.
    for (int k = 0; k < 8; k++) begin
      apply({31'b0, k[0]}, {31'b0, k[1]}, k[2], "R5 bit cell");
    end

    apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R7 all ones plus one");
    apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R7 all ones plus carry_in");
    apply(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R7 alternating full propagate");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 maximum total");
    apply(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R3 low carry into high part");
    apply(32'h0000_FFFF, 32'h0000_0000, 1'b1, "R4 carry_in at bit 0");
    apply(32'h0000_7FFF, 32'h0000_0001, 1'b0, "R3 no low carry");
    apply(32'hFFFF_0000, 32'h0001_0000, 1'b0, "R3 carry_out from high part");
    apply(32'hFFFF_8000, 32'h0000_8000, 1'b0, "R2 boundary carry into selected copy");
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, "R1 top bit carry");
    apply(32'h00FF_00FF, 32'h0001_0001, 1'b0, "R6 inner split boundaries");

    for (int n = 0; n < 3000; n++) begin
      apply($urandom, $urandom, 1'($urandom), "R1 random");
    end

    done = 1'b1;
    finish_run();
  end
endmodule